// File: doc/BRIEF.md
# Edge-Detect Interrupt Controller

This block watches a 24-bit input bus that has already been filtered and is synchronous to the clock. It looks for edges on channels that software selects. Each channel has two select bits. One arms the channel for a 0-to-1 change and the other arms it for a 1-to-0 change. Two global enables gate the rising and falling directions as a whole.

The first qualifying edge sets a sticky edge flag. Any later qualifying edge that arrives while that flag is still set also sets a sticky overflow flag. This tells software that at least one event was merged with an earlier one. An interrupt output combines both flags with per-flag enables and a master enable. The same value is shown in a status bit, so a handler on a shared line can tell whether this block raised it.

Software reaches the block through a byte-wide register port. Writes take effect on the clock edge and reads are combinational. The two select masks can be read back, so a driver can change some channels and keep the others. The flags are cleared by writing ones to a dedicated clear register.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, every mask byte, the control register and the status register read 0, and `irq_o` is low.
- R2: The rising-select mask is written and read as bytes at addresses 0, 1 and 2, and the falling-select mask at addresses 4, 5 and 6. Address 0 or 4 holds channels 7..0, and the next addresses hold the higher channels. Every bit reads back as written.
- R3: When control bit 3 is 1 and a channel's rising-select bit is 1, a 0-to-1 change of that channel sets status bit 0. The bit reads 1 at the first clock edge that samples the new level.
- R4: When control bit 4 is 1 and a channel's falling-select bit is 1, a 1-to-0 change of that channel sets status bit 0 at the same clock edge.
- R5: A change on a channel whose select bit for that direction is 0 leaves status bits 0 and 1 unchanged.
- R6: A qualifying edge that occurs while status bit 0 is already 1 sets status bit 1 (overflow).
- R7: A write to the clear register (address 10) with bit 3 set clears status bit 0, and with bit 2 set clears status bit 1. Both may be set in one write. The other bits of that write have no effect.
- R8: When a clear of a flag and a new qualifying edge fall on the same clock edge, that flag stays set.
- R9: `irq_o` equals control bit 2 AND ((status bit 0 AND control bit 0) OR (status bit 1 AND control bit 1)). The control register at address 9 reads back its five bits, so writing 0 there disables every interrupt.
- R10: Status bit 2 (address 8) always equals `irq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| din_i | input | 24 | Filtered, synchronous channel inputs |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register byte address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for `addr_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a clear and a fresh edge landing on the same clock edge. The bench drives the channel toggle and the clear write in the same cycle and expects both flags to remain set. The overflow-only state is also hard to reach: the bench creates two edges without clearing, then clears only the edge flag. From that state and the edge-only and both-flags states, it sweeps all eight combinations of the three interrupt enables. Each channel is swept separately through every rising and falling select pairing. Before each armed toggle, a neighbouring unselected channel is toggled first to show that it is ignored.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int unsigned AW = 5;

  localparam logic [AW-1:0] ADDR_RISE = 5'd0;
  localparam logic [AW-1:0] ADDR_FALL = 5'd4;
  localparam logic [AW-1:0] ADDR_STAT = 5'd8;
  localparam logic [AW-1:0] ADDR_CTRL = 5'd9;
  localparam logic [AW-1:0] ADDR_CLR  = 5'd10;

  localparam int unsigned CLR_EDGE_BIT = 3;
  localparam int unsigned CLR_OVF_BIT  = 2;

  // bit order matches the control register: [4] fall .. [0] edge
  typedef struct packed {
    logic fall_en;
    logic rise_en;
    logic irq_en;
    logic ovf_en;
    logic edge_en;
  } ctrl_t;
endpackage

// File: rtl/edge_sel_regs.sv
module edge_sel_regs
  import edge_irq_pkg::*;
#(
  parameter int unsigned   NUM_CH = 24,
  parameter logic [AW-1:0] BASE   = 5'd0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [7:0]        wdata_i,
  output logic [NUM_CH-1:0] mask_o,
  output logic [7:0]        rdata_o,
  output logic              hit_o
);
  localparam int unsigned NUM_BYTES = (NUM_CH + 7) / 8;

  logic [NUM_BYTES*8-1:0] mask_q;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    localparam logic [AW-1:0] BYTE_ADDR = AW'(int'(BASE) + b);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mask_q[b*8 +: 8] <= '0;
      else if (we_i && addr_i == BYTE_ADDR) mask_q[b*8 +: 8] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    hit_o   = 1'b0;
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (addr_i == AW'(int'(BASE) + b)) begin
        rdata_o = mask_q[b*8 +: 8];
        hit_o   = 1'b1;
      end
    end
  end

  assign mask_o = mask_q[NUM_CH-1:0];
endmodule

// File: rtl/edge_detect.sv
module edge_detect #(
  parameter int unsigned NUM_CH = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] din_i,
  input  logic [NUM_CH-1:0] rise_mask_i,
  input  logic [NUM_CH-1:0] fall_mask_i,
  input  logic              rise_en_i,
  input  logic              fall_en_i,
  output logic              evt_o
);
  logic [NUM_CH-1:0] prev_q;
  logic [NUM_CH-1:0] rise_hit, fall_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= din_i;
  end

  assign rise_hit = ~prev_q &  din_i & rise_mask_i & {NUM_CH{rise_en_i}};
  assign fall_hit =  prev_q & ~din_i & fall_mask_i & {NUM_CH{fall_en_i}};
  assign evt_o    = |(rise_hit | fall_hit);
endmodule

// File: rtl/edge_flags.sv
module edge_flags
  import edge_irq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  evt_i,
  input  logic  clr_edge_i,
  input  logic  clr_ovf_i,
  input  ctrl_t ctrl_i,
  output logic  edge_flag_o,
  output logic  ovf_flag_o,
  output logic  irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_flag_o <= 1'b0;
      ovf_flag_o  <= 1'b0;
    end else begin
      // a new event wins over a clear in the same cycle
      if (evt_i)           edge_flag_o <= 1'b1;
      else if (clr_edge_i) edge_flag_o <= 1'b0;
      if (evt_i && edge_flag_o) ovf_flag_o <= 1'b1;
      else if (clr_ovf_i)       ovf_flag_o <= 1'b0;
    end
  end

  assign irq_o = ctrl_i.irq_en &
                 ((edge_flag_o & ctrl_i.edge_en) | (ovf_flag_o & ctrl_i.ovf_en));
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] din_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] rise_mask, fall_mask;
  logic [7:0]        rise_rd, fall_rd;
  logic              rise_hit, fall_hit;
  ctrl_t             ctrl_q;
  logic              evt;
  logic              edge_flag, ovf_flag;
  logic              clr_we;

  edge_sel_regs #(.NUM_CH(NUM_CH), .BASE(ADDR_RISE)) i_rise_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .mask_o(rise_mask), .rdata_o(rise_rd), .hit_o(rise_hit)
  );

  edge_sel_regs #(.NUM_CH(NUM_CH), .BASE(ADDR_FALL)) i_fall_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .mask_o(fall_mask), .rdata_o(fall_rd), .hit_o(fall_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (we_i && addr_i == ADDR_CTRL) ctrl_q <= ctrl_t'(wdata_i[4:0]);
  end

  edge_detect #(.NUM_CH(NUM_CH)) i_detect (
    .clk_i, .rst_ni, .din_i,
    .rise_mask_i(rise_mask), .fall_mask_i(fall_mask),
    .rise_en_i(ctrl_q.rise_en), .fall_en_i(ctrl_q.fall_en),
    .evt_o(evt)
  );

  assign clr_we = we_i && addr_i == ADDR_CLR;

  edge_flags i_flags (
    .clk_i, .rst_ni,
    .evt_i(evt),
    .clr_edge_i(clr_we && wdata_i[CLR_EDGE_BIT]),
    .clr_ovf_i(clr_we && wdata_i[CLR_OVF_BIT]),
    .ctrl_i(ctrl_q),
    .edge_flag_o(edge_flag), .ovf_flag_o(ovf_flag), .irq_o
  );

  always_comb begin
    rdata_o = '0;
    if (rise_hit)                    rdata_o = rise_rd;
    else if (fall_hit)               rdata_o = fall_rd;
    else if (addr_i == ADDR_STAT)    rdata_o = {5'b0, irq_o, ovf_flag, edge_flag};
    else if (addr_i == ADDR_CTRL)    rdata_o = {3'b0, ctrl_q};
  end
endmodule

// File: rtl/edge_irq_chk.sv
module edge_irq_chk
  import edge_irq_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [7:0]    wdata_i,
  input logic [7:0]    rdata_o,
  input logic          irq_o,
  input logic          evt,
  input logic          edge_flag,
  input logic          ovf_flag,
  input ctrl_t         ctrl_q
);
  // R10
  status_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == ADDR_STAT |-> rdata_o[2] == irq_o);

  // R9
  irq_master_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.irq_en |-> !irq_o);

  // R6
  overflow_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt && edge_flag |=> ovf_flag);

  // R8
  event_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> edge_flag);

  // R7
  clear_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == ADDR_CLR && wdata_i[CLR_EDGE_BIT] && !evt |=> !edge_flag);

  // R7
  clear_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == ADDR_CLR && wdata_i[CLR_OVF_BIT] && !(evt && edge_flag) |=> !ovf_flag);
endmodule

bind edge_irq_ctrl edge_irq_chk i_edge_irq_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .evt(evt),
  .edge_flag(edge_flag), .ovf_flag(ovf_flag), .ctrl_q(ctrl_q)
);

// File: tb/test_edge_irq_ctrl.sv
`timescale 1ns/1ps
module test_edge_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] din = '0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  edge_irq_ctrl i_edge_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .din_i(din), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic set_din(input logic [23:0] v);
    @(negedge clk); din = v;
    @(negedge clk);
  endtask

  task automatic wr_masks(input logic [23:0] r, input logic [23:0] f);
    for (int b = 0; b < 3; b++) begin
      wr(5'(b), r[b*8 +: 8]);
      wr(5'(4 + b), f[b*8 +: 8]);
    end
  endtask

  task automatic chk_stat(input string req, input int exp_flags, input int exp_irq);
    logic [7:0] s;
    rd(5'd8, s);
    chk(req, int'(s[1:0]), exp_flags);
    chk("R10", int'(s[2]), int'(irq));
    chk(req, int'(irq), exp_irq);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    foreach (d[i]) ;
    for (int a = 0; a < 11; a++) begin
      rd(5'(a), d);
      chk("R1", int'(d), 0);
    end
    chk("R1", int'(irq), 0);

    // R2: mask readback with distinct byte patterns
    wr_masks(24'hA5_3C_81, 24'h5A_C3_18);
    for (int b = 0; b < 3; b++) begin
      rd(5'(b), d);     chk("R2", int'(d), int'((24'hA5_3C_81 >> (8*b)) & 8'hFF));
      rd(5'(4 + b), d); chk("R2", int'(d), int'((24'h5A_C3_18 >> (8*b)) & 8'hFF));
    end

    // R9: control readback
    wr(5'd9, 8'h1F);
    rd(5'd9, d); chk("R9", int'(d), 8'h1F);

    // R3 R4 R5: per-channel sweep over every select pairing and direction
    for (int ch = 0; ch < 24; ch++) begin
      for (int sel = 0; sel < 4; sel++) begin
        for (int dir = 0; dir < 2; dir++) begin
          logic [23:0] base, bit_ch, bit_nb;
          int exp_e;
          bit_ch = 24'(1) << ch;
          bit_nb = 24'(1) << ((ch + 1) % 24);
          base = (dir == 0) ? 24'h000000 : 24'hFFFFFF;
          wr_masks('0, '0);
          set_din(base);
          wr_masks(sel[0] ? bit_ch : 24'h0, sel[1] ? bit_ch : 24'h0);
          wr(5'd10, 8'h0C);
          set_din(base ^ bit_nb);
          chk_stat("R5", 0, 0);
          set_din(base ^ bit_nb ^ bit_ch);
          exp_e = (dir == 0) ? int'(sel[0]) : int'(sel[1]);
          chk_stat(dir == 0 ? "R3" : "R4", exp_e, exp_e);
        end
      end
    end

    // R3: rising direction gated by control bit 3
    wr_masks(24'hFFFFFF, 24'hFFFFFF);
    set_din('0);
    wr(5'd9, 8'h17);
    wr(5'd10, 8'h0C);
    set_din(24'h000010);
    chk_stat("R3", 0, 0);
    // R4: falling direction gated by control bit 4
    wr(5'd9, 8'h0F);
    set_din('0);
    chk_stat("R4", 0, 0);

    // R6: second event sets overflow
    wr(5'd9, 8'h1F);
    wr(5'd10, 8'h0C);
    set_din(24'h000001);
    chk_stat("R6", 1, 1);
    set_din(24'h000003);
    chk_stat("R6", 3, 1);

    // R7: unrelated clear bits do nothing, then each bit alone
    wr(5'd10, 8'hF3);
    chk_stat("R7", 3, 1);
    wr(5'd10, 8'h04);
    chk_stat("R7", 1, 1);
    wr(5'd10, 8'h08);
    chk_stat("R7", 0, 0);
    set_din(24'h000007);
    set_din(24'h000006);
    wr(5'd10, 8'h0C);
    chk_stat("R7", 0, 0);

    // R8: clear and new event on the same edge
    set_din(24'h000007);
    chk_stat("R8", 1, 1);
    @(negedge clk); din = 24'h000005; addr = 5'd10; wdata = 8'h0C; we = 1'b1;
    @(negedge clk); we = 1'b0;
    chk_stat("R8", 3, 1);

    // R9 R10: every enable combination for each flag state
    for (int st = 1; st < 4; st++) begin
      wr(5'd9, 8'h18);
      wr(5'd10, 8'h0C);
      set_din(24'h000000);
      wr(5'd10, 8'h0C);
      set_din(24'h000001);
      if (st != 1) set_din(24'h000003);
      if (st == 2) wr(5'd10, 8'h08);
      for (int c = 0; c < 8; c++) begin
        int e, o, exp_i;
        e = (st != 2) ? 1 : 0;
        o = (st != 1) ? 1 : 0;
        exp_i = ((c >> 2) & 1) & (((c & 1) & e) | (((c >> 1) & 1) & o));
        wr(5'd9, 8'(8'h18 | c));
        chk_stat("R9", (o << 1) | e, exp_i);
      end
    end
    wr(5'd9, 8'h00);
    chk_stat("R9", 3, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule